// File: doc/BRIEF.md
# Parity-Framed SPI Register Slave

This block is a 16-bit-frame SPI slave that gives an external host access to an on-chip register bank. The SPI wires are brought into a fast system clock domain through synchronizers and oversampled, so all frame logic runs on the system clock. The host drives the serial clock, which idles low. It changes MOSI on the rising serial-clock edge and samples MISO on the falling edge. The slave takes each MOSI bit on the falling edge and moves MISO on the rising edge, most significant bit first.

Each frame is either a command (read or write, with a 14-bit address) or, right after a write command, the data frame for that write. Every frame is checked for even parity and for a count of exactly 16 serial clocks. Any fault is recorded in a three-bit error register, whose OR is a sticky error flag. A faulty frame never reaches the register bank.

Responses are pipelined: the word shifted out during a frame carries the data requested by the frame before it, plus the error flag and an even-parity bit. A read of address 0x0001 returns the error register and clears it. The register bank sees one-cycle read and write strobes, and must return read data combinationally in the cycle of the read strobe. Chip select must stay high for at least six system clocks between frames. Each serial-clock phase must last at least five system clocks.

Top module: `spi_pf_slave`

## Requirements
- R1: A command frame has bit 15 as even parity over all 16 bits, bit 14 set for a read and clear for a write, and bits 13:0 as the address. A valid read of any address other than 0x0001 pulses `reg_rd` for one cycle with that address on `reg_addr`. `reg_rd` and `reg_wr` are never high together.
- R2: The response word has bit 15 equal to the XOR of bits 14:0, bit 14 equal to the error flag, and bits 13:0 equal to the data selected by the previous frame. Read data therefore appears one frame after the read command.
- R3: The slave captures MOSI on falling serial-clock edges and changes MISO only on rising serial-clock edges. Both directions send the most significant bit first.
- R4: A valid write command (bit 14 clear, frame not all zero) makes the next frame a data frame. A valid data frame with bit 14 clear pulses `reg_wr` once, with the stored address and bits 13:0 as `reg_wdata`. A data frame with bit 14 set sets error bit 1 (command invalid) and performs no write.
- R5: A full-length frame whose 16 bits have odd parity sets error bit 2 (parity). It causes no strobe and cancels any pending write.
- R6: A frame with fewer or more than 16 serial clocks sets error bit 0 (framing). It causes no strobe and cancels any pending write.
- R7: The error flag is the OR of the three error bits. Once set, it stays set across any number of frames until a valid read of address 0x0001.
- R8: A valid read of address 0x0001 issues no `reg_rd` and clears the error register. The next response carries the old error bits in data bits 2:0, with the flag clear.
- R9: An all-zero frame, when no write is pending, is a no-operation. It issues no strobe and selects data 0, so the next response is 0x0000 when no error is recorded.
- R10: After reset, MISO is low and both strobes are low. The first response shifted out is 0x0000.
- R11: Responses that follow a write command, a data frame or a faulty frame carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI wires |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from the host, active low |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial response data to the host |
| reg_addr | output | 14 | Register bank address for a read or write strobe |
| reg_wdata | output | 14 | Register bank write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 14 | Read data from the bank, valid in the `reg_rd` cycle |

## Verification
A wrong pending-write bit or stored address shows up within one frame, as a missing, extra or misdirected strobe on the bank port. A corrupted error register or a wrong response source shows up in the response word of the frame that follows, because the flag, the parity bit and the data are all compared bit by bit. A fault in the bit counter or in the edge choice garbles the next response or falsely sets the sticky flag, and that error then persists into every later response until a clear, which makes it easy to spot.

// File: rtl/spi_pf_pkg.sv
// Shared constants, types and helpers for the parity-framed SPI slave.
// Assumes a fixed 16-bit frame with a 14-bit address/data field.
package spi_pf_pkg;
    localparam int FRAME_W  = 16;
    localparam int DATA_W   = 14;
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int ERR_W    = 3;
    localparam int RW_BIT   = DATA_W;        // bit 14: read/write or error flag
    localparam int PAR_BIT  = FRAME_W - 1;   // bit 15: parity
    localparam logic [DATA_W-1:0] CLR_ADDR = DATA_W'(1);
    localparam int ERR_FRAME = 0;
    localparam int ERR_CMD   = 1;
    localparam int ERR_PAR   = 2;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_BANK = 2'd1,
        SRC_ERR  = 2'd2
    } resp_src_e;

    // Build a response word with even parity over the whole frame.
    function automatic logic [FRAME_W-1:0] pack_resp(input logic flag,
                                                     input logic [DATA_W-1:0] data);
        return {^{flag, data}, flag, data};
    endfunction
endpackage

// File: rtl/spi_pf_sync.sv
// Multi-stage synchronizer, one independent flop chain per bit.
// Assumes STAGES >= 2; RST_VAL gives each bit's reset level.
module spi_pf_sync #(
    parameter int           STAGES  = 2,
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the asynchronous input through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d_in[g]};
        end
        assign d_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_pf_shift.sv
// Serial frame engine: detects edges of the synchronized chip select and
// serial clock, shifts MOSI in on falling edges and MISO out on rising edges,
// counts serial clocks and flags the end of each frame.
// Assumes MOSI and SCK pass through synchronizers of equal depth.
module spi_pf_shift
    import spi_pf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_s,
    input  logic               sck_s,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               miso,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               cnt_ok,
    output logic               sck_rise
);
    logic               cs_p, sck_p;
    logic               cs_fall, cs_rise, sck_fall;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx_sh, tx_sh;

    assign cs_fall  = cs_p & ~cs_n_s;
    assign cs_rise  = ~cs_p & cs_n_s;
    assign sck_rise = ~cs_n_s & sck_s & ~sck_p;
    assign sck_fall = ~cs_n_s & ~sck_s & sck_p;

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p  <= 1'b1;
            sck_p <= 1'b0;
        end else begin
            cs_p  <= cs_n_s;
            sck_p <= sck_s;
        end
    end

    // Count falling edges in a frame, saturating one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    bit_cnt <= '0;
        else if (cs_fall)                              bit_cnt <= '0;
        else if (sck_fall && bit_cnt != CNT_W'(FRAME_W + 1)) bit_cnt <= bit_cnt + CNT_W'(1);
    end

    // Capture MOSI, MSB first, on each falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_sh <= '0;
        else if (sck_fall) rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
    end

    // Load the response at frame start and drive it out on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            miso  <= 1'b0;
        end else if (cs_fall) begin
            tx_sh <= tx_word;
        end else if (sck_rise) begin
            miso  <= tx_sh[FRAME_W-1];
            tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        end
    end

    // Signal the end of a frame one cycle after chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_done <= 1'b0;
        else        frame_done <= cs_rise;
    end

    assign rx_word = rx_sh;
    assign cnt_ok  = (bit_cnt == CNT_W'(FRAME_W));
endmodule

// File: rtl/spi_pf_ctrl.sv
// Frame decoder: validates parity and length, tracks a pending write,
// keeps the error register, drives bank strobes and prepares the response
// word for the next frame.
// Assumes reg_rdata is valid combinationally in the reg_rd cycle and that
// frames are separated by at least three system clocks of processing.
module spi_pf_ctrl
    import spi_pf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_done,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic               cnt_ok,
    input  logic [DATA_W-1:0]  reg_rdata,
    output logic [DATA_W-1:0]  reg_addr,
    output logic [DATA_W-1:0]  reg_wdata,
    output logic               reg_wr,
    output logic               reg_rd,
    output logic [FRAME_W-1:0] tx_word,
    output logic               err_flag,
    output logic               clr_evt,
    output logic               frame_bad
);
    logic              wr_pend;
    logic [DATA_W-1:0] pend_addr;
    logic [ERR_W-1:0]  err_reg, err_snap, new_err;
    resp_src_e         src;
    logic              load_pend;
    logic              par_bad, cmd_bad, is_read, is_clr, is_nop;
    logic [DATA_W-1:0] rx_addr, resp_data;

    assign rx_addr = rx_word[DATA_W-1:0];
    assign par_bad = cnt_ok & (^rx_word);
    assign cmd_bad = cnt_ok & ~par_bad & wr_pend & rx_word[RW_BIT];

    // Gather the fault bits of the frame just ended.
    always_comb begin
        new_err            = '0;
        new_err[ERR_FRAME] = ~cnt_ok;
        new_err[ERR_CMD]   = cmd_bad;
        new_err[ERR_PAR]   = par_bad;
    end

    assign frame_bad = |new_err;
    assign is_read   = ~wr_pend & rx_word[RW_BIT];
    assign is_clr    = is_read & (rx_addr == CLR_ADDR);
    assign is_nop    = ~wr_pend & (rx_word == '0);
    assign clr_evt   = frame_done & is_clr & ~frame_bad;
    assign err_flag  = |err_reg;

    // Accumulate faults into the sticky register; clear on the clear read.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_reg <= '0;
        else if (clr_evt)    err_reg <= '0;
        else if (frame_done) err_reg <= err_reg | new_err;
    end

    // Decode the frame, issue strobes and pick the response source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend   <= 1'b0;
            pend_addr <= '0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            err_snap  <= '0;
            src       <= SRC_ZERO;
            load_pend <= 1'b0;
        end else begin
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            load_pend <= frame_done;
            if (frame_done) begin
                src <= SRC_ZERO;
                if (frame_bad) begin
                    wr_pend <= 1'b0;
                end else if (wr_pend) begin
                    wr_pend   <= 1'b0;
                    reg_wr    <= 1'b1;
                    reg_addr  <= pend_addr;
                    reg_wdata <= rx_addr;
                end else if (is_clr) begin
                    err_snap <= err_reg;
                    src      <= SRC_ERR;
                end else if (is_read) begin
                    reg_rd   <= 1'b1;
                    reg_addr <= rx_addr;
                    src      <= SRC_BANK;
                end else if (!is_nop) begin
                    wr_pend   <= 1'b1;
                    pend_addr <= rx_addr;
                end
            end
        end
    end

    // Select the data field of the next response.
    always_comb begin
        unique case (src)
            SRC_BANK: resp_data = reg_rdata;
            SRC_ERR:  resp_data = {{(DATA_W-ERR_W){1'b0}}, err_snap};
            default:  resp_data = '0;
        endcase
    end

    // Latch the response word one cycle after decode, once bank data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_word <= '0;
        else if (load_pend) tx_word <= pack_resp(err_flag, resp_data);
    end
endmodule

// File: rtl/spi_pf_slave.sv
// Top of the parity-framed SPI slave: synchronizes the SPI wires,
// runs the serial frame engine and the frame decoder.
// Assumes SCK idles low and each SCK phase spans several system clocks.
module spi_pf_slave
    import spi_pf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [DATA_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic               cs_n_s, sck_s, mosi_s;
    logic [FRAME_W-1:0] tx_word, rx_word;
    logic               frame_done, cnt_ok, sck_rise;
    logic               err_flag, clr_evt, frame_bad;

    spi_pf_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_cs_n, spi_sck, spi_mosi}),
        .d_out ({cs_n_s, sck_s, mosi_s})
    );

    spi_pf_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (cs_n_s),
        .sck_s      (sck_s),
        .mosi_s     (mosi_s),
        .tx_word    (tx_word),
        .miso       (spi_miso),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .cnt_ok     (cnt_ok),
        .sck_rise   (sck_rise)
    );

    spi_pf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .cnt_ok     (cnt_ok),
        .reg_rdata  (reg_rdata),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .tx_word    (tx_word),
        .err_flag   (err_flag),
        .clr_evt    (clr_evt),
        .frame_bad  (frame_bad)
    );
endmodule

// File: rtl/spi_pf_slave_chk.sv
// Property checker for the parity-framed SPI slave, bound to its top.
module spi_pf_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sck_rise,
    input logic spi_miso,
    input logic reg_rd,
    input logic reg_wr,
    input logic frame_done,
    input logic frame_bad,
    input logic err_flag,
    input logic clr_evt
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr)); // R1

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd); // R1

    AST_MISO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(spi_miso)); // R3

    AST_BAD_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_bad) |=> (!reg_rd && !reg_wr)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_evt) |=> err_flag); // R7
endmodule

bind spi_pf_slave spi_pf_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise   (sck_rise),
    .spi_miso   (spi_miso),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .frame_done (frame_done),
    .frame_bad  (frame_bad),
    .err_flag   (err_flag),
    .clr_evt    (clr_evt)
);

// File: tb/spi_pf_slave_test.sv
module spi_pf_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso;
    logic [13:0] reg_addr, reg_wdata, reg_rdata;
    logic        reg_wr, reg_rd;

    int n_chk = 0;
    int n_fail = 0;

    logic [13:0] bank [16];
    logic [13:0] model_mem [16];
    logic [27:0] exp_wr_q[$];
    logic [13:0] exp_rd_q[$];
    logic [2:0]  m_err = '0;
    logic        m_pend = 1'b0;
    logic [13:0] m_pend_addr = '0;
    logic [15:0] m_resp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pf_slave uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata)
    );

    // Behavioural register bank.
    assign reg_rdata = bank[reg_addr[3:0]];
    always @(posedge clk) if (reg_wr) bank[reg_addr[3:0]] <= reg_wdata;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Strobe monitor, compared on every clock against the model's queues.
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            if (exp_wr_q.size() == 0) check(0, "R4 unexpected write", {4'h0, reg_addr, reg_wdata}, 0);
            else begin
                logic [27:0] e;
                e = exp_wr_q.pop_front();
                check({reg_addr, reg_wdata} == e, "R4 write strobe", {4'h0, reg_addr, reg_wdata}, {4'h0, e});
            end
        end
        if (rst_n && reg_rd) begin
            if (exp_rd_q.size() == 0) check(0, "R1 unexpected read", {18'h0, reg_addr}, 0);
            else begin
                logic [13:0] e;
                e = exp_rd_q.pop_front();
                check(reg_addr == e, "R1 read strobe", {18'h0, reg_addr}, {18'h0, e});
            end
        end
        if (rst_n && reg_rd && reg_wr) check(0, "R1 both strobes", 2'b11, 2'b00);
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] cmd(input logic rd, input logic [13:0] a);
        return {^{rd, a}, rd, a};
    endfunction

    function automatic logic [15:0] dat(input logic [13:0] d);
        return {^d, 1'b0, d};
    endfunction

    // Update the reference model for one frame and return the new response.
    task automatic model_step(input logic [15:0] w, input int nbits);
        logic [2:0]  e;
        logic [13:0] d;
        e = '0;
        d = '0;
        e[0] = (nbits != 16);
        e[2] = (nbits == 16) && (^w);
        e[1] = (nbits == 16) && !(^w) && m_pend && w[14];
        if (e != 0) begin
            m_err  = m_err | e;
            m_pend = 1'b0;
        end else if (m_pend) begin
            exp_wr_q.push_back({m_pend_addr, w[13:0]});
            model_mem[m_pend_addr[3:0]] = w[13:0];
            m_pend = 1'b0;
        end else if (w[14]) begin
            if (w[13:0] == 14'd1) begin
                d = {11'd0, m_err};
                m_err = '0;
            end else begin
                exp_rd_q.push_back(w[13:0]);
                d = model_mem[w[13:0] & 14'hF];
            end
        end else if (w != 16'h0) begin
            m_pend = 1'b1;
            m_pend_addr = w[13:0];
        end
        m_resp = {^{|m_err, d}, |m_err, d};
    endtask

    // Drive one frame of nbits serial clocks and compare the response.
    task automatic frame(input logic [15:0] w, input int nbits, input string tag);
        logic [15:0] exp_prev, got;
        exp_prev = m_resp;
        model_step(w, nbits);
        got = '0;
        spi_cs_n = 1'b0;
        wait_clk(HALF_SCK);
        for (int i = 0; i < nbits; i++) begin
            spi_sck  = 1'b1;
            spi_mosi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(HALF_SCK);
            got = {got[14:0], spi_miso};
            spi_sck = 1'b0;
            wait_clk(HALF_SCK);
        end
        spi_cs_n = 1'b1;
        wait_clk(12);
        if (nbits == 16) check(got == exp_prev, tag, got, exp_prev);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            bank[i]      = 14'(i * 14'h0459 + 14'h1203);
            model_mem[i] = 14'(i * 14'h0459 + 14'h1203);
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R10: reset state at the ports
        check(spi_miso == 1'b0, "R10 miso after reset", spi_miso, 0);
        check(!reg_rd && !reg_wr, "R10 strobes after reset", {reg_rd, reg_wr}, 0);

        frame(16'h0000, 16, "R10 first response zero");
        frame(16'h0000, 16, "R9 nop response");
        // R1/R2: read then pipelined data
        frame(cmd(1, 14'd5), 16, "R9 nop before read");
        frame(16'h0000, 16, "R2 read data one frame late");
        // R3: asymmetric pattern checks bit order
        frame(cmd(1, 14'd10), 16, "R3 msb first");
        frame(16'h0000, 16, "R3 bit order of read data");
        // R4: write then read back
        frame(cmd(0, 14'd3), 16, "R11 after nop");
        frame(dat(14'h2ABC), 16, "R11 after write command");
        frame(cmd(1, 14'd3), 16, "R11 after data frame");
        frame(16'h0000, 16, "R4 written data read back");
        // R2: back-to-back reads
        frame(cmd(1, 14'd7), 16, "R2 b2b first");
        frame(cmd(1, 14'd9), 16, "R2 b2b second");
        frame(16'h0000, 16, "R2 b2b third");
        // R5: parity error, R7 sticky, R8 clear
        frame(cmd(1, 14'd5) ^ 16'h8000, 16, "R5 before parity error");
        frame(16'h0000, 16, "R5 R11 response after parity error");
        frame(16'h0000, 16, "R7 flag still set");
        frame(cmd(1, 14'd1), 16, "R7 flag before clear");
        frame(16'h0000, 16, "R8 error register parity bit");
        frame(16'h0000, 16, "R8 flag cleared");
        // R6: short frame
        frame(cmd(1, 14'd4), 12, "R6 short");
        frame(16'h0000, 16, "R6 flag after short frame");
        frame(cmd(1, 14'd1), 16, "R6 clear");
        frame(16'h0000, 16, "R6 framing bit reported");
        // R6: long frame
        frame(cmd(1, 14'd4), 17, "R6 long");
        frame(cmd(1, 14'd1), 16, "R6 flag after long frame");
        frame(16'h0000, 16, "R6 framing bit after long frame");
        // R4: command invalid in data frame
        frame(cmd(0, 14'd4), 16, "R4 write cmd");
        frame({^{1'b1, 14'h0123}, 1'b1, 14'h0123}, 16, "R4 before bad data frame");
        frame(cmd(1, 14'd1), 16, "R4 flag after bad data frame");
        frame(16'h0000, 16, "R4 command invalid bit");
        // R5: error cancels pending write
        frame(cmd(0, 14'd6), 16, "R5 write cmd");
        frame(dat(14'h1555) ^ 16'h8000, 16, "R5 bad data parity");
        frame(cmd(1, 14'd6), 16, "R5 flag set");
        frame(cmd(1, 14'd1), 16, "R5 unchanged bank value");
        frame(16'h0000, 16, "R5 parity bit reported");
        frame(16'h0000, 16, "R9 clean nop");

        wait_clk(4);
        check(exp_wr_q.size() == 0, "R4 all writes seen", exp_wr_q.size(), 0);
        check(exp_rd_q.size() == 0, "R1 all reads seen", exp_rd_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule